// File: doc/BRIEF.md
# Serial Port Modem Status Register

This block keeps the read-only modem status byte of a serial port. Four active-low modem lines (carrier detect, ring indicator, data set ready, clear to send) are brought into the clock domain through a synchronizer. Their active-high levels appear in the upper nibble of the byte. Sticky change flags in the lower nibble record each change since the last read. A read strobe from the register-file decoder clears the flags. The block raises an interrupt request while any flag is set and interrupts are enabled.

A diagnostic loopback input swaps the level source. With loopback on, the four levels come from the port's own modem control outputs, not the pins. Change detection works on whichever source is selected, so a loopback test can set the flags without any external wiring. The bus decoder, the transmitter, the receiver and the rest of the register file sit outside this block.

Top module: `modem_status_reg`

## Requirements
- R1: `rd_data[7:4]` holds {carrier, ring, ready, send}, the inverse of `line_n[3]`, `line_n[2]`, `line_n[1]`, `line_n[0]`. A pin change reaches the byte on the third rising edge after it: two synchronizer stages and one status register.
- R2: With `loop_en` high, `rd_data[7:4]` shows {`mctl[3]`, `mctl[2]`, `mctl[0]`, `mctl[1]`} one edge after the control value is applied, and `line_n` has no effect on the byte.
- R3: Flag bits 3, 1 and 0 (carrier, ready, send) are set in the same cycle that status bits 7, 5 and 4 change. A change in either direction sets them.
- R4: Flag bit 2 is set only when status bit 6 goes from 1 to 0 (`line_n[2]` rising, the end of a ring). A 0-to-1 change of bit 6 leaves it clear.
- R5: A cycle with `rd_stb` high shows the flags as they were before the read. All four flags are zero after that edge, unless R6 applies.
- R6: A change detected on the same edge as a read sets its flag. Without a read, a set flag stays set.
- R7: During and after a synchronous reset on `rst`, the flags and `irq` are 0 and the upper nibble follows the current effective levels. No flag is set when reset is released with steady inputs.
- R8: Switching `loop_en` sets the flags of the lines whose effective level changes, following the rules of R3 and R4.
- R9: `irq` is registered. It is high in a cycle exactly when `irq_en` was high in the previous cycle and at least one flag is now set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_n | input | 4 | Active-low modem lines: [3] carrier, [2] ring, [1] ready, [0] send |
| loop_en | input | 1 | Diagnostic loopback select |
| mctl | input | 4 | Modem control outputs used as the source in loopback |
| rd_stb | input | 1 | Register read strobe; clears the flags |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Status byte: levels [7:4], change flags [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A corrupted synchronizer or previous-level register shows up as a wrong upper nibble. It also shows up as a flag that is set or missing on the edge where the level moves, which is at most three cycles after the pin. A flag register that loses its hold or clear behaviour appears on the cycle after a read strobe, or on the cycle after a cycle without one, as wrong low bits. A bad interrupt register shows up within one cycle as a mismatch between `irq` and the flags gated by the previous `irq_en`.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned LINE_W     = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  // line positions inside the level and flag nibbles
  localparam int unsigned IX_SEND    = 0;
  localparam int unsigned IX_READY   = 1;
  localparam int unsigned IX_RING    = 2;
  localparam int unsigned IX_CARRIER = 3;

  // lines whose flag fires only on the active-to-inactive change
  localparam logic [LINE_W-1:0] TRAIL_MASK = 4'b0100;

  // control-output bit that feeds a given line in loopback
  function automatic int unsigned loop_src(input int unsigned line);
    case (line)
      IX_CARRIER: return 3;
      IX_RING:    return 2;
      IX_READY:   return 0;
      default:    return 1;
    endcase
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/msr_level_sel.sv
module msr_level_sel #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             loop_en,
  input  logic [WIDTH-1:0] pin_sync_n,
  input  logic [WIDTH-1:0] ctl,
  output logic [WIDTH-1:0] lvl
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    localparam int unsigned SRC = msr_pkg::loop_src(g);
    assign lvl[g] = loop_en ? ctl[SRC] : ~pin_sync_n[g];
  end
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
  parameter int unsigned      WIDTH      = 4,
  parameter logic [WIDTH-1:0] TRAIL_ONLY = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  input  logic             rd_stb,
  input  logic             irq_en,
  output logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] flag_q,
  output logic             irq_q
);
  logic [WIDTH-1:0] evt;
  logic [WIDTH-1:0] flag_nxt;

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    if (TRAIL_ONLY[g]) begin : g_trail
      assign evt[g] = lvl_q[g] & ~lvl[g];
    end else begin : g_any
      assign evt[g] = lvl_q[g] ^ lvl[g];
    end
  end

  always_comb begin
    flag_nxt = rd_stb ? '0 : flag_q;
    flag_nxt = flag_nxt | evt;
  end

  always_ff @(posedge clk) begin
    lvl_q <= lvl;
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= irq_en & (|flag_nxt);
    end
  end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int unsigned LINES       = LINE_W,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINES-1:0]   line_n,
  input  logic               loop_en,
  input  logic [LINES-1:0]   mctl,
  input  logic               rd_stb,
  input  logic               irq_en,
  output logic [2*LINES-1:0] rd_data,
  output logic               irq
);
  localparam logic [LINES-1:0] RING_MASK = LINES'(TRAIL_MASK);

  logic [LINES-1:0] pin_sync_n;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] lvl_q;
  logic [LINES-1:0] flag_q;

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (line_n),
    .q   (pin_sync_n)
  );

  msr_level_sel #(.WIDTH(LINES)) u_sel (
    .loop_en    (loop_en),
    .pin_sync_n (pin_sync_n),
    .ctl        (mctl),
    .lvl        (lvl)
  );

  msr_delta #(.WIDTH(LINES), .TRAIL_ONLY(RING_MASK)) u_delta (
    .clk    (clk),
    .rst    (rst),
    .lvl    (lvl),
    .rd_stb (rd_stb),
    .irq_en (irq_en),
    .lvl_q  (lvl_q),
    .flag_q (flag_q),
    .irq_q  (irq)
  );

  assign rd_data = {lvl_q, flag_q};
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
  parameter int unsigned LINES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [LINES-1:0]   line_n,
  input logic               loop_en,
  input logic [LINES-1:0]   mctl,
  input logic               rd_stb,
  input logic               irq_en,
  input logic [2*LINES-1:0] rd_data,
  input logic               irq
);
  localparam int unsigned HI  = 2*LINES-1;
  localparam int unsigned S_C = LINES + msr_pkg::IX_CARRIER;
  localparam int unsigned S_G = LINES + msr_pkg::IX_RING;
  localparam int unsigned S_D = LINES + msr_pkg::IX_READY;
  localparam int unsigned S_S = LINES + msr_pkg::IX_SEND;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_level_follow_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !$past(loop_en)) |-> rd_data[HI:LINES] == ~$past(line_n, 3));

  assert_loop_map_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(loop_en)) |->
      (rd_data[S_C] == $past(mctl[3]) && rd_data[S_G] == $past(mctl[2]) &&
       rd_data[S_D] == $past(mctl[0]) && rd_data[S_S] == $past(mctl[1])));

  assert_carrier_delta_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$stable(rd_data[S_C])) |-> rd_data[msr_pkg::IX_CARRIER]);

  assert_ready_delta_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$stable(rd_data[S_D])) |-> rd_data[msr_pkg::IX_READY]);

  assert_send_delta_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$stable(rd_data[S_S])) |-> rd_data[msr_pkg::IX_SEND]);

  assert_ring_trail_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $fell(rd_data[S_G])) |-> rd_data[msr_pkg::IX_RING]);

  assert_ring_lead_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $rose(rd_data[S_G]) && !$past(rd_data[msr_pkg::IX_RING]))
      |-> !rd_data[msr_pkg::IX_RING]);

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (!$stable(rd_data[HI:LINES]) || rd_data[LINES-1:0] == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && rd_data[LINES-1:0] != '0) |=>
      ((rd_data[LINES-1:0] & $past(rd_data[LINES-1:0])) == $past(rd_data[LINES-1:0])));

  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) |-> (irq == ($past(irq_en) && (rd_data[LINES-1:0] != '0))));
endmodule

bind modem_status_reg msr_checker #(.LINES(LINES)) u_msr_chk (
  .clk     (clk),
  .rst     (rst),
  .line_n  (line_n),
  .loop_en (loop_en),
  .mctl    (mctl),
  .rd_stb  (rd_stb),
  .irq_en  (irq_en),
  .rd_data (rd_data),
  .irq     (irq)
);

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] line_n;
  logic       loop_en;
  logic [3:0] mctl;
  logic       rd_stb;
  logic       irq_en;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  modem_status_reg dut (
    .clk(clk), .rst(rst), .line_n(line_n), .loop_en(loop_en), .mctl(mctl),
    .rd_stb(rd_stb), .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    step(1);
    rd_stb = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; line_n = 4'b0101; loop_en = 1'b0; mctl = 4'h0;
    rd_stb = 1'b0; irq_en = 1'b0;
    step(5);
    // R7: reset value tracks the pins, flags clear
    chk("R7 reset byte", rd_data, 8'hA0);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);
    rst = 1'b0;
    step(4);
    chk("R7 no flag after release", rd_data, 8'hA0);

    // R1, R3, R4: every pin transition pair
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] av, bv, fl;
        av = 4'(a); bv = 4'(b);
        line_n = av;
        step(4);
        do_read();
        line_n = bv;
        step(2);
        chk("R1 latency hold", {4'h0, rd_data[7:4]}, {4'h0, ~av});
        step(1);
        fl = {av[3] ^ bv[3], ~av[2] & bv[2], av[1] ^ bv[1], av[0] ^ bv[0]};
        chk("R1 level", {4'h0, rd_data[7:4]}, {4'h0, ~bv});
        chk("R3 delta", {4'h0, rd_data[3], 1'b0, rd_data[1:0]}, {4'h0, fl[3], 1'b0, fl[1:0]});
        chk("R4 ring trail", {7'h0, rd_data[2]}, {7'h0, fl[2]});
      end
    end

    // R5: read cycle shows old flags, then zero
    line_n = 4'hF; step(4); do_read();
    line_n = 4'h0; step(3);
    rd_stb = 1'b1;
    #1;
    chk("R5 pre-clear view", rd_data, 8'hFB);
    step(1);
    rd_stb = 1'b0;
    chk("R5 cleared", rd_data, 8'hF0);

    // R2: loopback mapping, pins ignored
    loop_en = 1'b1;
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mv;
      mv = 4'(m);
      mctl = mv;
      line_n = ~mv ^ 4'h6;
      step(1);
      chk("R2 loop map", {4'h0, rd_data[7:4]}, {4'h0, mv[3], mv[2], mv[0], mv[1]});
    end
    mctl = 4'h9;
    step(1);
    line_n = 4'h9;
    step(4);
    chk("R2 pins ignored", {4'h0, rd_data[7:4]}, 8'h0A);

    // R8: entering and leaving loopback
    loop_en = 1'b0; mctl = 4'hF; line_n = 4'hF;
    step(4); do_read();
    chk("R8 idle", rd_data, 8'h00);
    loop_en = 1'b1;
    step(1);
    chk("R8 enter loop", rd_data, 8'hFB);
    do_read();
    loop_en = 1'b0;
    step(1);
    chk("R8 leave loop", rd_data, 8'h0F);

    // R6: event on the same edge as a read survives
    step(3); do_read();
    line_n = 4'hE; step(3);
    chk("R6 setup", rd_data, 8'h11);
    line_n = 4'h6; step(2);
    rd_stb = 1'b1;
    step(1);
    rd_stb = 1'b0;
    chk("R6 coincident event", rd_data, 8'h98);
    step(3);
    chk("R6 sticky hold", rd_data, 8'h98);

    // R9: interrupt gating and clear
    chk("R9 disabled", {7'h0, irq}, 8'h00);
    irq_en = 1'b1; step(1);
    chk("R9 enabled", {7'h0, irq}, 8'h01);
    irq_en = 1'b0; step(1);
    chk("R9 enable dropped", {7'h0, irq}, 8'h00);
    irq_en = 1'b1; step(1);
    chk("R9 re-enabled", {7'h0, irq}, 8'h01);
    rd_stb = 1'b1; step(1); rd_stb = 1'b0;
    chk("R9 cleared by read", {7'h0, irq}, 8'h00);
    step(2);
    chk("R9 no flags", {7'h0, irq}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule